// File: doc/BRIEF.md
# I2C Target Clock-Stretch and Acknowledge Controller

This controller sits beside the byte engine of an I2C target. The engine raises a one-cycle request on each SCL falling edge at which it needs a local decision. It tags the request with one of three kinds: the R/W bit of a matched read address, a byte about to arrive from the initiator, or a further byte the target must transmit. The controller checks the relevant FIFO flag. It then answers with a one-cycle response that carries an acknowledge decision and a replay select, which tells the engine to resend the byte it last shifted out.

When the FIFO is not ready and stretching is enabled, the controller asks the engine to hold SCL low. It keeps asking until software services the FIFO or a programmable count of system clocks expires. On expiry, the recovery depends on where the transfer stalled. A stalled address or a stalled receive byte is refused. A stalled transmit byte after the first one is covered by resending the previous byte. Every expiry sets a sticky status bit that software clears by writing one.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: After reset, holdScl, respValid, respAck, respReplay and statusTimeout are all 0.
- R2: reqKind encodes 2'b00 = address read R/W bit, 2'b01 = receive byte, 2'b10 = transmit byte. A request is blocked when txEmpty is 1 for kinds 2'b00 and 2'b10, or when rxFull is 1 for kind 2'b01. The other flag has no effect.
- R3: An unblocked request gives respValid high in the cycle after the request edge, with no SCL hold. respAck is 1 except as R9 states, and respReplay is 0.
- R4: A blocked request with stretchEn=1 drives holdScl high from the cycle after the request edge. When the blocking flag clears, holdScl drops and respValid rises together on the next edge, with the acknowledge rules of R3.
- R5: With timeoutEn=1, a hold whose flag stays set lasts exactly timeoutLimit+1 cycles and then resolves as a timeout. With timeoutEn=0, the hold lasts until the flag clears. A flag that clears on the same edge as the expiry wins over the timeout.
- R6: A timeout on an address read request answers respAck=0, respReplay=0.
- R7: A timeout on a receive byte answers respAck=0, respReplay=0, so the byte is neither stored nor acknowledged.
- R8: A timeout on a transmit byte answers respAck=1 with respReplay=1, which resends the previous byte.
- R9: With swNack=1, a receive-byte response (blocked or not, timed out or not) has respAck=0. swNack does not change address or transmit responses.
- R10: A blocked request with stretchEn=0 is answered in the next cycle with respAck=0, respReplay=0 and no hold.
- R11: statusTimeout goes to 1 in the same cycle as a timeout response. It stays 1 until a clrStatus pulse is taken. A timeout on the same edge as clrStatus leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle decision request from the byte engine |
| reqKind | input | 2 | Request kind (see R2) |
| txEmpty | input | 1 | Transmit FIFO empty flag |
| rxFull | input | 1 | Receive FIFO full flag |
| stretchEn | input | 1 | Enable automatic SCL stretching |
| timeoutEn | input | 1 | Enable the stretch timeout |
| timeoutLimit | input | CNT_W | Timeout length in system clocks, minus one |
| swNack | input | 1 | Software request to refuse received bytes |
| clrStatus | input | 1 | Write-one-to-clear pulse for the timeout status |
| holdScl | output | 1 | Request to hold SCL low |
| respValid | output | 1 | One-cycle decision strobe |
| respAck | output | 1 | 1 = acknowledge / proceed, 0 = NACK |
| respReplay | output | 1 | 1 = resend previously transmitted byte |
| statusTimeout | output | 1 | Sticky stretch-timeout status |

## Verification
The checker assumes the byte engine only requests when the controller is idle: reqValid is never high while holdScl or respValid is high. It also assumes that timeoutEn and timeoutLimit stay steady for the length of a hold. The bench meets both assumptions. It sets all configuration before each request and always leaves one idle cycle after a response. Its sweep covers every kind, both flag states, both enables, several limits, several release points and both swNack values. The release point is placed before, at and after the expiry edge, so the R5 priority is reached.

// File: rtl/stretch_pkg.sv
`timescale 1ns/1ps
package stretch_pkg;
  typedef enum logic [1:0] {
    KIND_ADDR_RD = 2'b00,
    KIND_RX      = 2'b01,
    KIND_TX      = 2'b10
  } kind_e;

  typedef struct packed {
    logic latchKind;
    logic cntClear;
    logic cntInc;
    logic setStatus;
  } strobes_t;
endpackage

// File: rtl/stretch_datapath.sv
`timescale 1ns/1ps
module stretch_datapath #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stretch_pkg::strobes_t     strobes,
  input  stretch_pkg::kind_e        reqKind,
  input  logic                      txEmpty,
  input  logic                      rxFull,
  input  logic [CNT_W-1:0]          timeoutLimit,
  input  logic                      clrStatus,
  output logic                      reqBlocked,
  output logic                      heldBlocked,
  output stretch_pkg::kind_e        heldKind,
  output logic                      cntAtLimit,
  output logic                      statusTimeout
);
  import stretch_pkg::*;

  logic [CNT_W-1:0] holdCnt;

  function automatic logic blockedFor(kind_e k, logic txE, logic rxF);
    return (k == KIND_RX) ? rxF : txE;
  endfunction

  assign reqBlocked  = blockedFor(reqKind, txEmpty, rxFull);
  assign heldBlocked = blockedFor(heldKind, txEmpty, rxFull);
  assign cntAtLimit  = (holdCnt >= timeoutLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldKind <= KIND_ADDR_RD;
    end else if (strobes.latchKind) begin
      heldKind <= reqKind;
    end
  end

  // counter saturates at the limit so a disabled timeout never wraps
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobes.cntClear) begin
      holdCnt <= '0;
    end else if (strobes.cntInc && !cntAtLimit) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusTimeout <= 1'b0;
    end else if (strobes.setStatus) begin
      statusTimeout <= 1'b1;
    end else if (clrStatus) begin
      statusTimeout <= 1'b0;
    end
  end
endmodule

// File: rtl/stretch_control.sv
`timescale 1ns/1ps
module stretch_control (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  stretch_pkg::kind_e    reqKind,
  input  logic                  reqBlocked,
  input  logic                  heldBlocked,
  input  stretch_pkg::kind_e    heldKind,
  input  logic                  cntAtLimit,
  input  logic                  stretchEn,
  input  logic                  timeoutEn,
  input  logic                  swNack,
  output stretch_pkg::strobes_t strobes,
  output logic                  holdScl,
  output logic                  respValid,
  output logic                  respAck,
  output logic                  respReplay
);
  import stretch_pkg::*;

  typedef enum logic {ST_IDLE, ST_HOLD} state_e;
  state_e state, stateNxt;
  logic respValidNxt, respAckNxt, respReplayNxt;

  always_comb begin
    stateNxt      = state;
    strobes       = '0;
    respValidNxt  = 1'b0;
    respAckNxt    = 1'b0;
    respReplayNxt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqBlocked) begin
            respValidNxt = 1'b1;
            respAckNxt   = !(reqKind == KIND_RX && swNack);
          end else if (!stretchEn) begin
            respValidNxt = 1'b1;
          end else begin
            stateNxt          = ST_HOLD;
            strobes.latchKind = 1'b1;
            strobes.cntClear  = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!heldBlocked) begin
          stateNxt     = ST_IDLE;
          respValidNxt = 1'b1;
          respAckNxt   = !(heldKind == KIND_RX && swNack);
        end else if (timeoutEn && cntAtLimit) begin
          stateNxt          = ST_IDLE;
          strobes.setStatus = 1'b1;
          respValidNxt      = 1'b1;
          respAckNxt        = (heldKind == KIND_TX);
          respReplayNxt     = (heldKind == KIND_TX);
        end else begin
          strobes.cntInc = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      respValid  <= 1'b0;
      respAck    <= 1'b0;
      respReplay <= 1'b0;
    end else begin
      state      <= stateNxt;
      respValid  <= respValidNxt;
      respAck    <= respAckNxt;
      respReplay <= respReplayNxt;
    end
  end

  assign holdScl = (state == ST_HOLD);
endmodule

// File: rtl/i2c_stretch_ctrl.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             stretchEn,
  input  logic             timeoutEn,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             swNack,
  input  logic             clrStatus,
  output logic             holdScl,
  output logic             respValid,
  output logic             respAck,
  output logic             respReplay,
  output logic             statusTimeout
);
  import stretch_pkg::*;

  strobes_t strobes;
  kind_e    kindIn, heldKind;
  logic     reqBlocked, heldBlocked, cntAtLimit;

  assign kindIn = kind_e'(reqKind);

  stretch_datapath #(.CNT_W(CNT_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqKind(kindIn),
    .txEmpty(txEmpty), .rxFull(rxFull), .timeoutLimit(timeoutLimit),
    .clrStatus(clrStatus), .reqBlocked(reqBlocked), .heldBlocked(heldBlocked),
    .heldKind(heldKind), .cntAtLimit(cntAtLimit), .statusTimeout(statusTimeout)
  );

  stretch_control control_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(kindIn),
    .reqBlocked(reqBlocked), .heldBlocked(heldBlocked), .heldKind(heldKind),
    .cntAtLimit(cntAtLimit), .stretchEn(stretchEn), .timeoutEn(timeoutEn),
    .swNack(swNack), .strobes(strobes), .holdScl(holdScl),
    .respValid(respValid), .respAck(respAck), .respReplay(respReplay)
  );
endmodule

// File: rtl/stretch_checker.sv
`timescale 1ns/1ps
module stretch_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             stretchEn,
  input logic             timeoutEn,
  input logic [CNT_W-1:0] timeoutLimit,
  input logic             clrStatus,
  input logic             holdScl,
  input logic             respValid,
  input logic             respAck,
  input logic             respReplay,
  input logic             statusTimeout
);
  logic [31:0] holdRun;

  always_ff @(posedge clk) begin
    if (!rstN) holdRun <= '0;
    else       holdRun <= holdScl ? holdRun + 1 : '0;
  end

  // input assumption: requests only arrive while idle
  assert_req_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (!holdScl && !respValid));

  assert_hold_needs_stretch_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdScl) |-> $past(stretchEn));

  assert_resp_releases_R4: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !holdScl);

  assert_resp_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_hold_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (holdScl && timeoutEn) |-> (holdRun <= 32'(timeoutLimit)));

  assert_replay_with_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    respReplay |-> (respValid && respAck));

  assert_status_on_timeout_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusTimeout) |-> (respValid && $past(holdScl)));

  assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusTimeout) && !$past(clrStatus)) |-> statusTimeout);
endmodule

bind i2c_stretch_ctrl stretch_checker #(.CNT_W(CNT_W)) checker_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .stretchEn(stretchEn),
  .timeoutEn(timeoutEn), .timeoutLimit(timeoutLimit), .clrStatus(clrStatus),
  .holdScl(holdScl), .respValid(respValid), .respAck(respAck),
  .respReplay(respReplay), .statusTimeout(statusTimeout)
);

// File: tb/i2c_stretch_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic txEmpty = 1'b0, rxFull = 1'b0;
  logic stretchEn = 1'b0, timeoutEn = 1'b0, swNack = 1'b0, clrStatus = 1'b0;
  logic [CNT_W-1:0] timeoutLimit = '0;
  logic holdScl, respValid, respAck, respReplay, statusTimeout;

  int nChecks = 0;
  int nFails = 0;
  logic expStatus = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_stretch_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .txEmpty(txEmpty), .rxFull(rxFull), .stretchEn(stretchEn),
    .timeoutEn(timeoutEn), .timeoutLimit(timeoutLimit), .swNack(swNack),
    .clrStatus(clrStatus), .holdScl(holdScl), .respValid(respValid),
    .respAck(respAck), .respReplay(respReplay), .statusTimeout(statusTimeout)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request; u = hold cycles observed before the blocking flag is released
  task automatic runTxn(input int kind, input bit blk, input bit se, input bit te,
                        input int lim, input int u, input bit sw, input bit clrAtHold);
    int holds = 0;
    int guard = 0;
    bit isRx = (kind == 1);
    bit expTo, expAck, expRep;
    int expHold;
    string tag;
    @(negedge clk);
    txEmpty = isRx ? 1'b1 : blk;   // R2: flag of the other kind is ignored
    rxFull  = isRx ? blk : 1'b1;
    stretchEn = se; timeoutEn = te; timeoutLimit = CNT_W'(lim); swNack = sw;
    reqKind = 2'(kind); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid && guard < 40) begin
      if (holdScl) begin
        holds++;
        if (clrAtHold && holds == 1) clrStatus = 1'b1;
        if (holds == u) begin
          if (isRx) rxFull = 1'b0; else txEmpty = 1'b0;
        end
      end
      guard++;
      @(negedge clk);
    end
    clrStatus = 1'b0;
    // expected values from the requirements
    expTo = 0; expRep = 0; expHold = 0;
    if (!blk) begin
      expAck = !(isRx && sw);              tag = "R3";
    end else if (!se) begin
      expAck = 0;                           tag = "R10";
    end else if (te && u > lim + 1) begin
      expTo = 1; expHold = lim + 1;
      expAck = (kind == 2); expRep = (kind == 2);
      tag = (kind == 0) ? "R6" : (kind == 1) ? "R7" : "R8";
    end else begin
      expHold = u; expAck = !(isRx && sw); tag = "R4";
    end
    if (isRx && sw) tag = "R9";
    if (expTo) expStatus = 1'b1;
    check({tag, " respValid"}, int'(respValid), 1);
    check({tag, " respAck"}, int'(respAck), int'(expAck));
    check({tag, " respReplay"}, int'(respReplay), int'(expRep));
    check("R5 hold cycles", holds, expHold);
    check("R4 hold released", int'(holdScl), 0);
    check("R11 status", int'(statusTimeout), int'(expStatus));
    @(negedge clk);
  endtask

  task automatic clearStatus();
    clrStatus = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0;
    expStatus = 1'b0;
    check("R11 status cleared", int'(statusTimeout), 0);
  endtask

  initial begin
    int n = 0;
    int lims[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    check("R1 holdScl", int'(holdScl), 0);
    check("R1 respValid", int'(respValid), 0);
    check("R1 respAck", int'(respAck), 0);
    check("R1 respReplay", int'(respReplay), 0);
    check("R1 statusTimeout", int'(statusTimeout), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 2; b++)
        for (int se = 0; se < 2; se++)
          for (int te = 0; te < 2; te++)
            for (int li = 0; li < 3; li++)
              for (int u = 1; u <= 5; u++)
                for (int sw = 0; sw < 2; sw++) begin
                  runTxn(k, b[0], se[0], te[0], lims[li], u, sw[0], 1'b0);
                  n++;
                  if (n % 4 == 0) clearStatus();
                end
    // R11: timeout coinciding with a clear keeps the status set
    runTxn(1, 1'b1, 1'b1, 1'b1, 0, 9, 1'b0, 1'b0);
    runTxn(1, 1'b1, 1'b1, 1'b1, 0, 9, 1'b0, 1'b1);
    check("R11 set beats clear", int'(statusTimeout), 1);
    clearStatus();
    // R5: long hold with timeout disabled never resolves early
    runTxn(2, 1'b1, 1'b1, 1'b0, 0, 12, 1'b0, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule